// File: doc/BRIEF.md
# Six-Source Interrupt Mask and Mode Controller

This block gathers interrupt requests from six peripheral sources into one request line toward the CPU. Each source has a pending flag. Peripherals raise a flag with a per-source set strobe and drop it with a per-source clear strobe. A mask register chooses which pending flags may reach the CPU. The request line is high whenever at least one pending flag is also enabled in the mask.

Software reaches the block through a single-cycle register port with three registers: pending (read-only), mask and mode. Software never writes the mask and mode registers as plain values. Instead, each bit is driven by a pair of command bits in the write word, one to clear it and one to set it. A write to the mode register can also acknowledge the display-processor source. It does this by clearing that source's pending flag. The mode register holds three flags: a memory-interface mode, an initialisation mode and an external-bus mode.

Top module: `irq_mask_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, the pending, mask and mode registers read zero and `irq` is low.
- R2: Source bit positions are fixed as follows: 0 signal processor, 1 serial, 2 audio, 3 video, 4 parallel, 5 display processor. A pulse on `src_set[i]` makes pending bit i read 1 from the next cycle onward.
- R3: A pulse on `src_clr[i]` clears pending bit i. If `src_set[i]` is high in the same cycle, the bit ends up set.
- R4: A bus write to address 0 (pending) has no effect on any register.
- R5: A write to address 1 (mask) treats `wdata` bit 2k as "clear mask bit k" and bit 2k+1 as "set mask bit k", for k = 0..5. Clears are applied first and sets second, so a word with both bits high leaves the mask bit at 1.
- R6: `irq` is high exactly when the bitwise AND of pending and mask is nonzero. It reflects each register update in the cycle that follows the update.
- R7: A write to address 2 (mode) treats `wdata` bit 2j as "clear flag j" and bit 2j+1 as "set flag j", for j = 0..2. Flag 0 is memory-interface mode, flag 1 is init mode and flag 2 is external-bus mode. If both command bits are high, the set is applied and the clear is ignored.
- R8: In a mode write, `wdata` bit 6 clears pending bit 5 (display processor). If `src_set[5]` is high in the same cycle, the bit stays set.
- R9: `rdata` is combinational from `addr`. Address 0 returns pending in bits [5:0], address 1 returns mask in bits [5:0], address 2 returns mode in bits [2:0], and address 3 returns zero. All other bits read zero.
- R10: Command bits that are zero leave their target bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised internally |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 pending, 1 mask, 2 mode, 3 reserved |
| wdata | input | 12 | Write command word |
| rdata | output | 32 | Read data for `addr` |
| src_set | input | 6 | Per-source pending set strobes |
| src_clr | input | 6 | Per-source pending clear strobes |
| irq | output | 1 | Combined interrupt request to the CPU |

## Verification
The assertions check the following rules on every cycle: set strobes raising pending flags, clear-versus-set priority, writes to the pending address being ignored, both-commands words on the mask and mode registers leaving the bit set, the display-processor acknowledge, the reserved address reading zero, and an enabled source raising `irq`. Some properties can only be shown by the directed scenarios. These are that every command position maps to the right bit, that zero command bits preserve the other bits, that `irq` falls again when a mask bit or a pending flag is removed, and the exact read layout of each register.

// File: rtl/irq_mask_ctrl_pkg.sv
package irq_mask_ctrl_pkg;
  localparam int NUM_SRC  = 6;
  localparam int NUM_MODE = 3;
  localparam int DP_SRC   = 5;

  typedef enum logic [1:0] {
    RA_PEND = 2'd0,
    RA_MASK = 2'd1,
    RA_MODE = 2'd2,
    RA_RSVD = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/irq_cmd_bits.sv
// A register whose bits change only through clear/set command pairs.
// Clears are applied before sets, so a set always wins.
module irq_cmd_bits #(
  parameter int NBITS = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [2*NBITS-1:0] cmd,
  output logic [NBITS-1:0]   q
);
  logic [NBITS-1:0] q_d;

  always_comb begin
    q_d = q;
    for (int k = 0; k < NBITS; k++) begin
      if (cmd[2*k])   q_d[k] = 1'b0;
      if (cmd[2*k+1]) q_d[k] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= q_d;
  end
endmodule

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int NSRC   = 6,
  parameter int ACK_IX = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  input  logic            ack_i,
  output logic [NSRC-1:0] q
);
  logic [NSRC-1:0] drop;
  logic [NSRC-1:0] q_d;
  logic            en;

  always_comb begin
    drop         = clr_i;
    drop[ACK_IX] = clr_i[ACK_IX] | ack_i;
    q_d          = (q & ~drop) | set_i;
    en           = (|set_i) | (|drop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= q_d;
  end
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
  import irq_mask_ctrl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CMD_W  = 2*NUM_SRC
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         addr,
  input  logic [CMD_W-1:0]   wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic [NUM_SRC-1:0] src_set,
  input  logic [NUM_SRC-1:0] src_clr,
  output logic               irq
);
  localparam int ACK_BIT = 2*NUM_MODE;

  logic                srst_n;
  logic                mask_we;
  logic                mode_we;
  logic                dp_ack;
  logic [NUM_SRC-1:0]  pend_q;
  logic [NUM_SRC-1:0]  mask_q;
  logic [NUM_MODE-1:0] mode_q;

  irq_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  always_comb begin
    mask_we = wr_en && (addr == RA_MASK);
    mode_we = wr_en && (addr == RA_MODE);
    dp_ack  = mode_we && wdata[ACK_BIT];
  end

  irq_cmd_bits #(.NBITS(NUM_SRC)) u_mask (
    .clk   (clk),
    .rst_n (srst_n),
    .wr_en (mask_we),
    .cmd   (wdata[2*NUM_SRC-1:0]),
    .q     (mask_q)
  );

  irq_cmd_bits #(.NBITS(NUM_MODE)) u_mode (
    .clk   (clk),
    .rst_n (srst_n),
    .wr_en (mode_we),
    .cmd   (wdata[2*NUM_MODE-1:0]),
    .q     (mode_q)
  );

  irq_pending #(.NSRC(NUM_SRC), .ACK_IX(DP_SRC)) u_pend (
    .clk   (clk),
    .rst_n (srst_n),
    .set_i (src_set),
    .clr_i (src_clr),
    .ack_i (dp_ack),
    .q     (pend_q)
  );

  always_comb begin
    rdata = '0;
    case (addr)
      RA_PEND: rdata[NUM_SRC-1:0]  = pend_q;
      RA_MASK: rdata[NUM_SRC-1:0]  = mask_q;
      RA_MODE: rdata[NUM_MODE-1:0] = mode_q;
      default: rdata = '0;
    endcase
  end

  assign irq = |(pend_q & mask_q);
endmodule

// File: rtl/irq_mask_ctrl_chk.sv
module irq_mask_ctrl_chk #(
  parameter int NSRC   = 6,
  parameter int NMODE  = 3,
  parameter int CMD_W  = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              srst_n,
  input logic              wr_en,
  input logic [1:0]        addr,
  input logic [CMD_W-1:0]  wdata,
  input logic [DATA_W-1:0] rdata,
  input logic [NSRC-1:0]   src_set,
  input logic [NSRC-1:0]   src_clr,
  input logic              irq,
  input logic [NSRC-1:0]   pend_q,
  input logic [NSRC-1:0]   mask_q,
  input logic [NMODE-1:0]  mode_q
);
  for (genvar gi = 0; gi < NSRC; gi++) begin : g_src
    // R2
    set_raises_chk: assert property (@(posedge clk) disable iff (!srst_n)
      src_set[gi] |=> pend_q[gi]);
    // R3
    clr_drops_chk: assert property (@(posedge clk) disable iff (!srst_n)
      (src_clr[gi] && !src_set[gi] && !(gi == NSRC-1 && wr_en)) |=> !pend_q[gi]);
  end

  // R4
  pend_wr_ignored_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (wr_en && addr == 2'd0 && src_set == '0 && src_clr == '0) |=> $stable(pend_q));

  // R5
  mask_both_set_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (wr_en && addr == 2'd1 && wdata[1:0] == 2'b11) |=> mask_q[0]);

  // R6
  enabled_src_irq_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (src_set[2] && mask_q[2] && !(wr_en && addr == 2'd1)) |=> irq);

  // R7
  mode_set_wins_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (wr_en && addr == 2'd2 && wdata[3:2] == 2'b11) |=> mode_q[1]);

  // R8
  dp_ack_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (wr_en && addr == 2'd2 && wdata[2*NMODE] && !src_set[NSRC-1]) |=> !pend_q[NSRC-1]);

  // R9
  rsvd_read_zero_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (addr == 2'd3) |-> (rdata == '0));
endmodule

bind irq_mask_ctrl irq_mask_ctrl_chk #(
  .NSRC(6), .NMODE(3), .CMD_W(CMD_W), .DATA_W(DATA_W)
) u_chk (
  .clk     (clk),
  .srst_n  (srst_n),
  .wr_en   (wr_en),
  .addr    (addr),
  .wdata   (wdata),
  .rdata   (rdata),
  .src_set (src_set),
  .src_clr (src_clr),
  .irq     (irq),
  .pend_q  (pend_q),
  .mask_q  (mask_q),
  .mode_q  (mode_q)
);

// File: tb/irq_mask_ctrl_bench.sv
module irq_mask_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  addr;
  logic [11:0] wdata;
  logic [31:0] rdata;
  logic [5:0]  src_set;
  logic [5:0]  src_clr;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  irq_mask_ctrl u_irq_mask_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .src_set(src_set), .src_clr(src_clr), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [11:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic read_chk(input string req, input logic [1:0] a, input logic [31:0] exp);
    addr = a;
    #2;
    check(req, rdata, exp);
  endtask

  task automatic strobe(input logic [5:0] s, input logic [5:0] c);
    @(negedge clk);
    src_set = s; src_clr = c;
    @(negedge clk);
    src_set = '0; src_clr = '0;
  endtask

  task automatic t_reset;
    read_chk("R1 pend", 2'd0, 32'h0);
    read_chk("R1 mask", 2'd1, 32'h0);
    read_chk("R1 mode", 2'd2, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_pending;
    strobe(6'b100101, 6'b0);
    read_chk("R2 set strobes", 2'd0, 32'h25);
    strobe(6'b000000, 6'b000001);
    read_chk("R3 clear strobe", 2'd0, 32'h24);
    strobe(6'b000100, 6'b000100);
    read_chk("R3 set beats clear", 2'd0, 32'h24);
    bus_write(2'd0, 12'hFFF);
    read_chk("R4 pending write ignored", 2'd0, 32'h24);
    read_chk("R4 mask untouched", 2'd1, 32'h0);
    read_chk("R4 mode untouched", 2'd2, 32'h0);
  endtask

  task automatic t_mask;
    // set bits 0, 2, 5 (cmd bits 1, 5, 11); bit 3 with both commands
    bus_write(2'd1, 12'b1000_1110_0010);
    read_chk("R5 mask set and both", 2'd1, 32'h2D);
    bus_write(2'd1, 12'b0000_0100_0000);
    read_chk("R5 mask clear bit3", 2'd1, 32'h25);
    bus_write(2'd1, 12'h000);
    read_chk("R10 zero commands", 2'd1, 32'h25);
  endtask

  task automatic t_irq;
    // pending = 0x24, mask = 0x25 -> overlap
    check("R6 irq overlap", {31'b0, irq}, 32'h1);
    bus_write(2'd1, 12'b0001_0001_0000); // clear mask 2 and 4
    check("R6 irq still via bit5", {31'b0, irq}, 32'h1);
    bus_write(2'd1, 12'b0100_0000_0000); // clear mask 5
    check("R6 irq low no overlap", {31'b0, irq}, 32'h0);
    strobe(6'b000001, 6'b0);
    check("R6 irq from src0", {31'b0, irq}, 32'h1);
    strobe(6'b0, 6'b000001);
    check("R6 irq drops with pending", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_mode;
    bus_write(2'd2, 12'b0000_0010_0010); // set flag0, flag2
    read_chk("R7 mode set", 2'd2, 32'h5);
    bus_write(2'd2, 12'b0000_0000_1101); // flag0 clear, flag1 both
    read_chk("R7 set wins and clear", 2'd2, 32'h6);
    bus_write(2'd2, 12'h000);
    read_chk("R10 mode zero commands", 2'd2, 32'h6);
    bus_write(2'd1, 12'b1000_0000_0000); // enable mask 5
    check("R6 irq from dp", {31'b0, irq}, 32'h1);
    bus_write(2'd2, 12'b0000_0100_0000); // acknowledge dp
    read_chk("R8 dp ack", 2'd0, 32'h04);
    read_chk("R8 mode untouched", 2'd2, 32'h6);
    check("R8 irq low after ack", {31'b0, irq}, 32'h0);
    @(negedge clk);
    wr_en = 1'b1; addr = 2'd2; wdata = 12'b0000_0100_0000; src_set = 6'b100000;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0; src_set = '0;
    read_chk("R8 set beats ack", 2'd0, 32'h24);
  endtask

  task automatic t_read;
    read_chk("R9 reserved address", 2'd3, 32'h0);
    read_chk("R9 mask layout", 2'd1, 32'h21);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    src_set = '0; src_clr = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_pending;
    t_mask;
    t_irq;
    t_mode;
    t_read;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule